// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recently used virtual-page to physical-page mappings in front of a page table walker. Each lookup presents a virtual address. The page number is compared against every valid entry at once. On a match the physical address and the permission bits come back in the same cycle. When nothing matches, the block asks the walker for the mapping. It writes a good result into an entry, and the requester, which holds its lookup steady, then hits on the replay. A walk that reports a fault installs nothing, and the fault is handed straight back to the requester.

Software keeps the contents coherent in two ways. Writing the page-table base register, as happens on a context switch, empties the whole buffer. A single-page invalidate removes the one entry that holds a given page number. Entries are never written back to the page table. A write that lands on an entry whose dirty bit is still clear counts as a miss. The walker can then mark the page dirty in memory, and the refreshed mapping replaces the old entry in place. When a new mapping needs room, a free entry is used first; otherwise the least recently used entry is replaced.

Top module: `xlat_buffer`

## Requirements
- R1: When `lk_valid` is high and a usable entry matches the page number (bits 31:12 of `lk_vaddr`), `lk_hit` is high in that same cycle. `lk_paddr` is then the stored physical page followed by the 12-bit page offset, and `lk_perm` gives the stored permissions (bit 0 read, bit 1 write, bit 2 execute).
- R2: A valid lookup with no usable match raises `walk_req` from the next cycle. `walk_vpn` carries the missing page, and both hold steady until `walk_done` is seen. Out of reset, `walk_req`, `lk_hit` and `lk_fault` are low.
- R3: A `walk_done` without `walk_fault` installs the returned page, permissions and dirty bit. A lookup held through the walk hits in the cycle after `walk_done`.
- R4: `walk_done` with `walk_fault` drives `lk_fault` high in that same cycle and installs nothing, so a later lookup of the same page walks again.
- R5: A pulse on `ptbase_wr` clears every entry at the next edge. A fill that completes in that same cycle is discarded.
- R6: A pulse on `inv_en` clears only the entry whose page number equals `inv_vpn`. Other entries keep hitting.
- R7: A write lookup (`lk_write` high) that matches an entry with a clear dirty bit is a miss and starts a walk. The refill replaces that same entry, and later writes hit.
- R8: A fill goes into the lowest-numbered free entry whenever one exists, so ENTRIES distinct pages all stay resident after a flush.
- R9: With no free entry, the fill replaces the least recently used entry. Hits and fills both count as uses.
- R10: At most one valid entry holds any given page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_write | input | 1 | Lookup is for a store |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation available this cycle |
| lk_paddr | output | 32 | Translated physical address |
| lk_perm | output | 3 | Permissions of the matching entry |
| lk_fault | output | 1 | Walk ended in a fault (pass-through) |
| walk_req | output | 1 | Walk request to the page table walker |
| walk_vpn | output | 20 | Page number to walk |
| walk_done | input | 1 | Walker has a result this cycle |
| walk_fault | input | 1 | Walk result is a fault |
| walk_ppn | input | 20 | Physical page from the walker |
| walk_perm | input | 3 | Permissions from the walker |
| walk_dirty | input | 1 | Dirty bit from the walker |
| ptbase_wr | input | 1 | Page-table base register written: flush all |
| inv_en | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page number to invalidate |

## Verification
The assertions rely on the requester holding its lookup unchanged from a miss until it sees a hit or a fault. They also assume that the walker pulses `walk_done` only while `walk_req` is high, and only once per request. The stimulus meets both conditions. The driver keeps every lookup up until completion, then drops it, and a walker model answers each request exactly once, two cycles after it sees the request. The walker derives the returned page, permissions and fault from the page number. It sets the dirty bit from the pending access type, so that a store miss comes back dirty.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
    parameter int VPN_W  = 20;
    parameter int PPN_W  = 20;
    parameter int PERM_W = 3;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
        logic              dirty;
    } xlat_entry_t;

    typedef struct packed {
        logic             busy;
        logic [VPN_W-1:0] vpn;
    } walk_state_t;
endpackage

// File: rtl/xlat_lru.sv
`timescale 1ns/1ps
module xlat_lru #(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             reset_order,
    output logic [IDX_W-1:0] victim_idx
);
    // Age per entry: 0 = newest, ENTRIES-1 = oldest; ages form a permutation.
    typedef struct packed {
        logic [ENTRIES-1:0][IDX_W-1:0] age;
    } lru_state_t;

    lru_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reset_order) begin
            for (int i = 0; i < ENTRIES; i++) st_d.age[i] = IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++)
                if (st_q.age[i] < st_q.age[touch_idx]) st_d.age[i] = st_q.age[i] + 1'b1;
            st_d.age[touch_idx] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) st_q.age[i] <= IDX_W'(i);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (st_q.age[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
    end

    generate
        if (ENTRIES > 1) begin : g_lru_chk
            // R9: the entry just used is never the next replacement choice
            assert_touched_not_victim_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (touch_en && !reset_order) |=> (victim_idx != $past(touch_idx)));
        end
    endgenerate
endmodule

// File: rtl/xlat_cam.sv
`timescale 1ns/1ps
module xlat_cam import xlat_pkg::*; #(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  look_vpn,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic              kill_en,
    input  logic [VPN_W-1:0]  kill_vpn,
    input  logic              flush_en,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  xlat_entry_t       wr_data,
    output logic [ENTRIES-1:0] look_hit,
    output logic [ENTRIES-1:0] fill_hit,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [PPN_W-1:0]  look_ppn,
    output logic [PERM_W-1:0] look_perm,
    output logic              look_dirty
);
    typedef struct packed {
        xlat_entry_t [ENTRIES-1:0] ent;
    } cam_state_t;

    cam_state_t st_d, st_q;

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
            assign valid_vec[i] = st_q.ent[i].valid;
            assign look_hit[i]  = st_q.ent[i].valid && (st_q.ent[i].vpn == look_vpn);
            assign fill_hit[i]  = st_q.ent[i].valid && (st_q.ent[i].vpn == fill_vpn);
        end
    endgenerate

    always_comb begin
        look_ppn   = '0;
        look_perm  = '0;
        look_dirty = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_hit[i]) begin
                look_ppn   = st_q.ent[i].ppn;
                look_perm  = st_q.ent[i].perm;
                look_dirty = st_q.ent[i].dirty;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.ent[wr_idx] = wr_data;
        if (kill_en) begin
            for (int i = 0; i < ENTRIES; i++)
                if (st_d.ent[i].vpn == kill_vpn) st_d.ent[i].valid = 1'b0;
        end
        if (flush_en) begin
            for (int i = 0; i < ENTRIES; i++) st_d.ent[i].valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Checker state: last invalidated page and entries still holding it.
    logic [VPN_W-1:0]   last_kill_q;
    logic [ENTRIES-1:0] stale_vec;
    always_ff @(posedge clk) last_kill_q <= kill_vpn;
    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_stale
            assign stale_vec[i] = st_q.ent[i].valid && (st_q.ent[i].vpn == last_kill_q);
        end
    endgenerate

    // R10: no page is held twice
    assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_hit) && $onehot0(fill_hit));
    // R6: an invalidated page is gone after the edge
    assert_kill_removes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kill_en |=> (stale_vec == '0));
endmodule

// File: rtl/xlat_buffer.sv
`timescale 1ns/1ps
module xlat_buffer import xlat_pkg::*; #(
    parameter int ENTRIES = 64,
    parameter int OFF_W   = 12,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int VA_W  = VPN_W + OFF_W,
    localparam int PA_W  = PPN_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [PERM_W-1:0] lk_perm,
    output logic              lk_fault,
    output logic              walk_req,
    output logic [VPN_W-1:0]  walk_vpn,
    input  logic              walk_done,
    input  logic              walk_fault,
    input  logic [PPN_W-1:0]  walk_ppn,
    input  logic [PERM_W-1:0] walk_perm,
    input  logic              walk_dirty,
    input  logic              ptbase_wr,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn
);
    walk_state_t st_d, st_q;

    logic [VPN_W-1:0]   look_vpn;
    logic [ENTRIES-1:0] look_hit, fill_hit, valid_vec;
    logic [PPN_W-1:0]   look_ppn;
    logic [PERM_W-1:0]  look_perm;
    logic               look_dirty, usable, fill_en, touch_en;
    logic               any_free, any_same;
    logic [IDX_W-1:0]   hit_idx, free_idx, same_idx, victim_idx, fill_idx, touch_idx;
    xlat_entry_t        fill_entry;

    assign look_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign usable   = (|look_hit) && (!lk_write || look_dirty);
    assign lk_hit   = lk_valid && usable;
    assign lk_paddr = {look_ppn, lk_vaddr[OFF_W-1:0]};
    assign lk_perm  = look_perm;
    assign lk_fault = st_q.busy && walk_done && walk_fault;
    assign walk_req = st_q.busy;
    assign walk_vpn = st_q.vpn;

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        same_idx = '0;
        any_free = 1'b0;
        any_same = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (look_hit[i]) hit_idx = IDX_W'(i);
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
            if (fill_hit[i]) begin
                same_idx = IDX_W'(i);
                any_same = 1'b1;
            end
        end
        // Refresh in place, else a free slot, else the oldest entry.
        fill_idx = any_same ? same_idx : (any_free ? free_idx : victim_idx);
    end

    always_comb begin
        st_d = st_q;
        if (!st_q.busy && lk_valid && !usable) begin
            st_d.busy = 1'b1;
            st_d.vpn  = look_vpn;
        end else if (st_q.busy && walk_done) begin
            st_d.busy = 1'b0;
        end
        fill_en          = st_q.busy && walk_done && !walk_fault && !ptbase_wr;
        fill_entry.valid = 1'b1;
        fill_entry.vpn   = st_q.vpn;
        fill_entry.ppn   = walk_ppn;
        fill_entry.perm  = walk_perm;
        fill_entry.dirty = walk_dirty;
        touch_en         = fill_en || lk_hit;
        touch_idx        = fill_en ? fill_idx : hit_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    xlat_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_vpn  (look_vpn),
        .fill_vpn  (st_q.vpn),
        .kill_en   (inv_en),
        .kill_vpn  (inv_vpn),
        .flush_en  (ptbase_wr),
        .wr_en     (fill_en),
        .wr_idx    (fill_idx),
        .wr_data   (fill_entry),
        .look_hit  (look_hit),
        .fill_hit  (fill_hit),
        .valid_vec (valid_vec),
        .look_ppn  (look_ppn),
        .look_perm (look_perm),
        .look_dirty(look_dirty)
    );

    xlat_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .reset_order(ptbase_wr),
        .victim_idx (victim_idx)
    );

    // R2: a miss starts a walk on the next cycle
    assert_miss_walks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit && !st_q.busy) |=> walk_req);
    // R2: the request and its page stay put until answered
    assert_walk_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_done) |=> (walk_req && (walk_vpn == $past(walk_vpn))));
    // R3: a good walk result leaves the page resident
    assert_fill_resident_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !inv_en) |=> (|fill_hit));
    // R4: a faulting walk installs nothing
    assert_fault_no_install_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault && !(|fill_hit)) |=> !(|fill_hit));
    // R5: flush empties the buffer, including a same-cycle fill
    assert_flush_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ptbase_wr |=> (valid_vec == '0));
endmodule

// File: tb/xlat_buffer_bench.sv
`timescale 1ns/1ps
module xlat_buffer_bench;
    import xlat_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_fault, walk_req;
    logic [31:0] lk_paddr;
    logic [2:0]  lk_perm;
    logic [19:0] walk_vpn;
    logic        walk_done = 1'b0, walk_fault = 1'b0, walk_dirty = 1'b0;
    logic [19:0] walk_ppn = '0;
    logic [2:0]  walk_perm = '0;
    logic        ptbase_wr = 1'b0, inv_en = 1'b0;
    logic [19:0] inv_vpn = '0;

    always #2 clk = ~clk;

    xlat_buffer u_xlat_buffer (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
        .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
        .lk_fault(lk_fault), .walk_req(walk_req), .walk_vpn(walk_vpn),
        .walk_done(walk_done), .walk_fault(walk_fault), .walk_ppn(walk_ppn),
        .walk_perm(walk_perm), .walk_dirty(walk_dirty), .ptbase_wr(ptbase_wr),
        .inv_en(inv_en), .inv_vpn(inv_vpn)
    );

    typedef struct packed {
        logic [31:0] pa;
        logic [2:0]  perm;
        logic        fault;
        logic        walked;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0, fails = 0;
    bit    cur_write = 1'b0;
    bit    walked_seen = 1'b0;
    exp_t  mon_e;
    string mon_t;

    function automatic logic [19:0] ppn_of(logic [19:0] v);
        return v ^ 20'hA5A5A;
    endfunction
    function automatic logic [2:0] perm_of(logic [19:0] v);
        return {v[1], 2'b11};
    endfunction
    function automatic bit faults(logic [19:0] v);
        return v[19:16] == 4'hF;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Monitor: pop an expected item on every completion (hit or fault).
    always @(negedge clk) begin
        if (rst_n) begin
            if (walk_req) walked_seen = 1'b1;
            if (lk_valid && (lk_hit || lk_fault)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected completion", 32'(lk_hit), 32'd0);
                end else begin
                    mon_e = exp_q.pop_front();
                    mon_t = tag_q.pop_front();
                    check(lk_fault == mon_e.fault, mon_t, "fault", 32'(lk_fault), 32'(mon_e.fault));
                    check(walked_seen == mon_e.walked, mon_t, "walked", 32'(walked_seen), 32'(mon_e.walked));
                    if (!mon_e.fault) begin
                        check(lk_paddr == mon_e.pa, mon_t, "paddr", lk_paddr, mon_e.pa);
                        check(lk_perm == mon_e.perm, mon_t, "perm", 32'(lk_perm), 32'(mon_e.perm));
                    end
                end
                walked_seen = 1'b0;
            end
        end
    end

    // Walker model: answers each request two cycles after seeing it.
    initial begin
        logic [19:0] wv;
        forever begin
            @(negedge clk);
            if (rst_n && walk_req) begin
                wv = walk_vpn;
                repeat (2) @(posedge clk);
                #1;
                walk_done  = 1'b1;
                walk_ppn   = ppn_of(wv);
                walk_perm  = perm_of(wv);
                walk_dirty = cur_write;
                walk_fault = faults(wv);
                @(posedge clk);
                #1;
                walk_done  = 1'b0;
                walk_fault = 1'b0;
            end
        end
    end

    // Driver: holds a lookup until it completes, pushing its expectation.
    task automatic access(logic [19:0] v, logic [11:0] off, bit wr, bit exp_walk, string tag);
        exp_t e;
        bit   done = 1'b0;
        @(posedge clk);
        #1;
        lk_valid = 1'b1;
        lk_write = wr;
        lk_vaddr = {v, off};
        cur_write = wr;
        walked_seen = 1'b0;
        e.fault  = faults(v);
        e.walked = exp_walk || faults(v);
        e.pa     = {ppn_of(v), off};
        e.perm   = perm_of(v);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (lk_hit || lk_fault) begin
                done = 1'b1;
                break;
            end
        end
        if (!done) begin
            check(1'b0, tag, "lookup never completed", 32'd0, 32'd1);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
        @(posedge clk);
        #1;
        lk_valid = 1'b0;
        lk_write = 1'b0;
    endtask

    task automatic flush_all();
        @(posedge clk); #1; ptbase_wr = 1'b1;
        @(posedge clk); #1; ptbase_wr = 1'b0;
    endtask

    task automatic drop_page(logic [19:0] v);
        @(posedge clk); #1; inv_en = 1'b1; inv_vpn = v;
        @(posedge clk); #1; inv_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL all watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(walk_req == 1'b0, "R2", "reset walk_req", 32'(walk_req), 32'd0);
        check(lk_hit == 1'b0, "R1", "reset lk_hit", 32'(lk_hit), 32'd0);
        check(lk_fault == 1'b0, "R4", "reset lk_fault", 32'(lk_fault), 32'd0);

        // R2/R3: cold misses fill and replay; R1: later hits need no walk
        access(20'h12345, 12'h44C, 1'b0, 1'b1, "R3 cold miss A");
        access(20'h12345, 12'h008, 1'b0, 1'b0, "R1 hit A new offset");
        access(20'h00ABC, 12'hFFF, 1'b0, 1'b1, "R2 miss B");
        access(20'h07712, 12'h000, 1'b0, 1'b1, "R2 miss C");
        access(20'h00ABC, 12'h123, 1'b0, 1'b0, "R1 hit B");

        // R4: faults pass through and never install
        access(20'hF0001, 12'h010, 1'b0, 1'b1, "R4 fault first");
        access(20'hF0001, 12'h010, 1'b0, 1'b1, "R4 fault not installed");

        // R7: store to a clean entry walks and refreshes in place
        access(20'h12345, 12'h100, 1'b1, 1'b1, "R7 store to clean entry");
        access(20'h12345, 12'h104, 1'b1, 1'b0, "R7 store after refill");
        access(20'h12345, 12'h108, 1'b0, 1'b0, "R7 load after refill");

        // R6: single-page invalidate
        drop_page(20'h00ABC);
        access(20'h07712, 12'h020, 1'b0, 1'b0, "R6 other page kept");
        access(20'h00ABC, 12'h020, 1'b0, 1'b1, "R6 dropped page walks");

        // R5: flush empties everything
        flush_all();
        access(20'h12345, 12'h000, 1'b0, 1'b1, "R5 A gone after flush");
        access(20'h07712, 12'h000, 1'b0, 1'b1, "R5 C gone after flush");

        // R8: after a flush, 64 distinct pages all fit
        flush_all();
        for (int i = 0; i < 64; i++)
            access(20'h00100 + 20'(i), 12'h010, 1'b0, 1'b1, "R8 fill free entry");
        for (int i = 0; i < 64; i++)
            access(20'h00100 + 20'(i), 12'h020, 1'b0, 1'b0, "R8 all pages resident");

        // R9: oldest entry replaced; recently used one kept
        access(20'h00100, 12'h030, 1'b0, 1'b0, "R9 touch first page");
        access(20'h00200, 12'h030, 1'b0, 1'b1, "R9 new page evicts");
        access(20'h00100, 12'h040, 1'b0, 1'b0, "R9 recently used kept");
        access(20'h00101, 12'h040, 1'b0, 1'b1, "R9 least recent evicted");

        repeat (4) @(posedge clk);
        check(exp_q.size() == 0, "R1", "pending expectations", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule